// File: doc/BRIEF.md
# Two-Group Level Interrupt Aggregator

This block gathers sixteen level-sensitive interrupt requests into a single active-low request line for a host processor. The requests form two groups of eight: a PCI group and a miscellaneous group. Each raw request is brought into the clock domain through a two-flop synchronizer. A host reaches the block through a small synchronous register port with six byte-wide registers. There is a mask and a live status view for each group, a route byte, and a general control byte.

The PCI group does not drive the request line directly. It is folded into one bit of the miscellaneous group, so the host reads the miscellaneous status first and then the PCI status when that bit shows activity. Status bits are active-low, and a value of all ones means that nothing is pending. The route byte takes miscellaneous sources off the shared request line. The pen-down source has its own dedicated active-low output that takes over when that source's route bit is cleared.

Top module: `irq_cascade_agg`

## Requirements
- R1: The register offsets are fixed: 0 PCI mask, 1 PCI status, 2 route, 3 miscellaneous mask, 4 miscellaneous status, 5 control. Offsets 0, 2, 3 and 5 read back the last value written to them. Offsets 6 and 7 read as 0x00 and ignore writes.
- R2: After a synchronous reset, both masks read 0xFF, route reads 0xFF, control reads 0x00, both outputs are high, and with idle inputs both status registers read 0xFF.
- R3: PCI status (offset 1) reads the bitwise inverse of the synchronized `pci_req` levels, with no masking applied and no latching. Writes to offsets 1 and 4 change nothing.
- R4: Miscellaneous status (offset 4) reads the inverse of the synchronized `misc_req` levels, except for bit 1. Bit 1 reads 0 when `misc_req[1]` is high or when any PCI source is high with its PCI mask bit at 0. When every PCI source is masked, only `misc_req[1]` can clear bit 1.
- R5: `cascade_irq_n` is low when some miscellaneous bit i has an effective request, a miscellaneous mask bit of 0 and a route bit of 1. It stays low for as long as that condition holds.
- R6: `side_irq_n` is low exactly when miscellaneous bit 4 has a request, its mask bit is 0 and its route bit is 0. With route at 0xFD that source still reaches the cascade line. With route bit 4 at 0, it does not.
- R7: A mask bit of 1 keeps its source from affecting either output line and from affecting the PCI summary bit.
- R8: A change on a request input reaches the outputs on the third rising edge after it. Two of those edges belong to the synchronizer and one to the output register. Read data appears on the rising edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the offset presented in the previous cycle |
| pci_req | input | 8 | Raw PCI group requests, active-high levels |
| misc_req | input | 8 | Raw miscellaneous group requests, active-high levels |
| cascade_irq_n | output | 1 | Shared request to the host, active-low |
| side_irq_n | output | 1 | Dedicated pen-down request, active-low |

## Verification
The bench builds the block with its defaults: groups eight bits wide, two synchronizer stages, the summary at bit 1 and the pen-down source at bit 4. With those values the exact three-edge input latency can be probed. The interplay of the summary bit with a raw level on `misc_req[1]` is exercised, as is the hand-over of bit 4 between the two output lines. Random mask, route and input patterns are checked against a bench model of the status inversion, the masking and the routing.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] OFF_PCI_MASK  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_PCI_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] OFF_ROUTE     = 3'd2;
  localparam logic [REG_AW-1:0] OFF_MISC_MASK = 3'd3;
  localparam logic [REG_AW-1:0] OFF_MISC_STAT = 3'd4;
  localparam logic [REG_AW-1:0] OFF_CTRL      = 3'd5;

  localparam logic [REG_DW-1:0] RST_MASK  = 8'hFF;
  localparam logic [REG_DW-1:0] RST_ROUTE = 8'hFF;
  localparam logic [REG_DW-1:0] RST_CTRL  = 8'h00;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int GRP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [GRP_W-1:0]  reg_wdata,
  input  logic [GRP_W-1:0]  pci_stat_n,
  input  logic [GRP_W-1:0]  misc_stat_n,
  output logic [GRP_W-1:0]  pci_mask_q,
  output logic [GRP_W-1:0]  misc_mask_q,
  output logic [GRP_W-1:0]  route_q,
  output logic [GRP_W-1:0]  ctrl_q,
  output logic [GRP_W-1:0]  reg_rdata
);
  logic [GRP_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      pci_mask_q  <= GRP_W'(RST_MASK);
      misc_mask_q <= GRP_W'(RST_MASK);
      route_q     <= GRP_W'(RST_ROUTE);
      ctrl_q      <= GRP_W'(RST_CTRL);
    end else if (reg_we) begin
      case (reg_addr)
        OFF_PCI_MASK:  pci_mask_q  <= reg_wdata;
        OFF_ROUTE:     route_q     <= reg_wdata;
        OFF_MISC_MASK: misc_mask_q <= reg_wdata;
        OFF_CTRL:      ctrl_q      <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_PCI_MASK:  rd_mux = pci_mask_q;
      OFF_PCI_STAT:  rd_mux = pci_stat_n;
      OFF_ROUTE:     rd_mux = route_q;
      OFF_MISC_MASK: rd_mux = misc_mask_q;
      OFF_MISC_STAT: rd_mux = misc_stat_n;
      OFF_CTRL:      rd_mux = ctrl_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irqagg_combine.sv
module irqagg_combine #(
  parameter int GRP_W   = 8,
  parameter int SUM_IDX = 1,
  parameter int PEN_IDX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] pci_live,
  input  logic [GRP_W-1:0] misc_raw,
  input  logic [GRP_W-1:0] pci_mask_q,
  input  logic [GRP_W-1:0] misc_mask_q,
  input  logic [GRP_W-1:0] route_q,
  output logic [GRP_W-1:0] misc_live,
  output logic             cascade_irq_n,
  output logic             side_irq_n
);
  logic             pci_any;
  logic [GRP_W-1:0] misc_enabled;
  logic [GRP_W-1:0] to_cascade;
  logic             to_side;

  assign pci_any = |(pci_live & ~pci_mask_q);

  for (genvar i = 0; i < GRP_W; i++) begin : g_bit
    if (i == SUM_IDX) begin : g_sum
      assign misc_live[i] = misc_raw[i] | pci_any;
    end else begin : g_pass
      assign misc_live[i] = misc_raw[i];
    end
  end

  assign misc_enabled = misc_live & ~misc_mask_q;
  assign to_cascade   = misc_enabled & route_q;
  assign to_side      = misc_enabled[PEN_IDX] & ~route_q[PEN_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      cascade_irq_n <= 1'b1;
      side_irq_n    <= 1'b1;
    end else begin
      cascade_irq_n <= ~|to_cascade;
      side_irq_n    <= ~to_side;
    end
  end
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
  import irqagg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SUM_IDX     = 1,
  parameter int PEN_IDX     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [REG_DW-1:0] pci_req,
  input  logic [REG_DW-1:0] misc_req,
  output logic              cascade_irq_n,
  output logic              side_irq_n
);
  localparam int GRP_W = REG_DW;

  logic [GRP_W-1:0] pci_live;
  logic [GRP_W-1:0] misc_sync;
  logic [GRP_W-1:0] misc_live;
  logic [GRP_W-1:0] pci_mask_q;
  logic [GRP_W-1:0] misc_mask_q;
  logic [GRP_W-1:0] route_q;
  logic [GRP_W-1:0] ctrl_q;
  logic             ctrl_unused;

  irqagg_sync #(.WIDTH(GRP_W), .STAGES(SYNC_STAGES)) u_sync_pci (
    .clk(clk), .rst(rst), .d_async(pci_req), .q_sync(pci_live)
  );

  irqagg_sync #(.WIDTH(GRP_W), .STAGES(SYNC_STAGES)) u_sync_misc (
    .clk(clk), .rst(rst), .d_async(misc_req), .q_sync(misc_sync)
  );

  irqagg_combine #(.GRP_W(GRP_W), .SUM_IDX(SUM_IDX), .PEN_IDX(PEN_IDX)) u_combine (
    .clk(clk), .rst(rst),
    .pci_live(pci_live), .misc_raw(misc_sync),
    .pci_mask_q(pci_mask_q), .misc_mask_q(misc_mask_q), .route_q(route_q),
    .misc_live(misc_live),
    .cascade_irq_n(cascade_irq_n), .side_irq_n(side_irq_n)
  );

  irqagg_regs #(.GRP_W(GRP_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .pci_stat_n(~pci_live), .misc_stat_n(~misc_live),
    .pci_mask_q(pci_mask_q), .misc_mask_q(misc_mask_q),
    .route_q(route_q), .ctrl_q(ctrl_q),
    .reg_rdata(reg_rdata)
  );

  // control byte is storage only; read back through the register port
  assign ctrl_unused = ^ctrl_q;
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int SUM_IDX = 1,
  parameter int PEN_IDX = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_we,
  input logic [REG_DW-1:0] reg_wdata,
  input logic [REG_DW-1:0] reg_rdata,
  input logic              cascade_irq_n,
  input logic              side_irq_n,
  input logic [REG_DW-1:0] pci_live,
  input logic [REG_DW-1:0] misc_live,
  input logic [REG_DW-1:0] pci_mask_q,
  input logic [REG_DW-1:0] misc_mask_q,
  input logic [REG_DW-1:0] route_q
);
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == OFF_PCI_MASK) |=> (pci_mask_q == $past(reg_wdata))); // R1

  AST_PCI_STAT_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFF_PCI_STAT) |=> (reg_rdata == ~$past(pci_live))); // R3

  AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (rst)
    (|(pci_live & ~pci_mask_q)) |-> misc_live[SUM_IDX]); // R4

  AST_CASCADE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cascade_irq_n == !$past(|(misc_live & ~misc_mask_q & route_q)))); // R5

  AST_SIDE_ROUTED: assert property (@(posedge clk) disable iff (rst)
    !side_irq_n |-> ($past(route_q[PEN_IDX]) == 1'b0)); // R6

  AST_SIDE_MASKED: assert property (@(posedge clk) disable iff (rst)
    !side_irq_n |-> ($past(misc_mask_q[PEN_IDX]) == 1'b0)); // R7
endmodule

bind irq_cascade_agg irqagg_checker #(.SUM_IDX(SUM_IDX), .PEN_IDX(PEN_IDX)) u_chk (
  .clk(clk), .rst(rst),
  .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .cascade_irq_n(cascade_irq_n), .side_irq_n(side_irq_n),
  .pci_live(pci_live), .misc_live(misc_live),
  .pci_mask_q(pci_mask_q), .misc_mask_q(misc_mask_q), .route_q(route_q)
);

// File: tb/irq_cascade_agg_bench.sv
module irq_cascade_agg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pci_req = '0;
  logic [7:0] misc_req = '0;
  logic       cascade_irq_n;
  logic       side_irq_n;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  logic [7:0] m_pm, m_mm, m_rt, m_ctl;

  always #10 clk = ~clk;

  irq_cascade_agg u_irq_cascade_agg (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pci_req(pci_req), .misc_req(misc_req),
    .cascade_irq_n(cascade_irq_n), .side_irq_n(side_irq_n)
  );

  function automatic logic [7:0] eff_misc(logic [7:0] p, logic [7:0] m, logic [7:0] pm);
    logic [7:0] e;
    e = m;
    e[1] = m[1] | (|(p & ~pm));
    return e;
  endfunction

  function automatic logic exp_casc(logic [7:0] p, logic [7:0] m);
    return ~|(eff_misc(p, m, m_pm) & ~m_mm & m_rt);
  endfunction

  function automatic logic exp_side(logic [7:0] p, logic [7:0] m);
    logic [7:0] e;
    e = eff_misc(p, m, m_pm);
    return ~(e[4] & ~m_mm[4] & ~m_rt[4]);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: m_pm = d;
      3'd2: m_rt = d;
      3'd3: m_mm = d;
      3'd5: m_ctl = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    chk({tag, " R5 cascade"}, {7'b0, cascade_irq_n}, {7'b0, exp_casc(pci_req, misc_req)});
    chk({tag, " R6 side"}, {7'b0, side_irq_n}, {7'b0, exp_side(pci_req, misc_req)});
    rd(3'd1, v); chk({tag, " R3 pci status"}, v, ~pci_req);
    rd(3'd4, v); chk({tag, " R4 misc status"}, v, ~eff_misc(pci_req, misc_req, m_pm));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    m_pm = 8'hFF; m_mm = 8'hFF; m_rt = 8'hFF; m_ctl = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk("R2 cascade", {7'b0, cascade_irq_n}, 8'h01);
    chk("R2 side", {7'b0, side_irq_n}, 8'h01);
    rd(3'd0, v); chk("R2 pci mask", v, 8'hFF);
    rd(3'd2, v); chk("R2 route", v, 8'hFF);
    rd(3'd3, v); chk("R2 misc mask", v, 8'hFF);
    rd(3'd5, v); chk("R2 control", v, 8'h00);
    rd(3'd1, v); chk("R2 pci status", v, 8'hFF);
    rd(3'd4, v); chk("R2 misc status", v, 8'hFF);

    // R1 read back, unused offsets
    wr(3'd5, 8'hA5); rd(3'd5, v); chk("R1 control", v, 8'hA5);
    wr(3'd6, 8'h3C); rd(3'd6, v); chk("R1 offset 6", v, 8'h00);
    rd(3'd7, v); chk("R1 offset 7", v, 8'h00);

    // R3 status writes ignored, live levels
    pci_req = 8'h81;
    wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    settle();
    rd(3'd1, v); chk("R3 pci status after write", v, 8'h7E);
    rd(3'd4, v); chk("R3 misc status after write", v, 8'hFF); // all PCI masked
    pci_req = 8'h00;

    // R8 latency: unmask misc bit 0, then raise it
    wr(3'd3, 8'hFE);
    settle();
    misc_req = 8'h01;
    repeat (2) @(negedge clk);
    chk("R8 before third edge", {7'b0, cascade_irq_n}, 8'h01);
    @(negedge clk);
    chk("R8 at third edge", {7'b0, cascade_irq_n}, 8'h00);
    repeat (5) @(negedge clk);
    chk("R5 held while pending", {7'b0, cascade_irq_n}, 8'h00);
    misc_req = 8'h00;
    settle();
    chk("R5 released", {7'b0, cascade_irq_n}, 8'h01);

    // R4 summary through unmasked PCI bit, cleared by full PCI mask
    wr(3'd3, 8'hED);
    wr(3'd0, 8'hF7);
    pci_req = 8'h08;
    settle();
    check_all("R4 summary");
    wr(3'd0, 8'hFF);
    settle();
    check_all("R7 pci masked");
    misc_req = 8'h02;
    settle();
    check_all("R4 raw bit1");
    misc_req = 8'h00; pci_req = 8'h00;

    // R6 pen-down routing
    wr(3'd2, 8'hFD);
    misc_req = 8'h10;
    settle();
    check_all("R6 route FD");
    wr(3'd2, 8'hEF);
    settle();
    check_all("R6 route bit4 clear");
    chk("R6 side low", {7'b0, side_irq_n}, 8'h00);
    wr(3'd3, 8'hFF);
    settle();
    check_all("R7 pen masked");
    misc_req = 8'h00;

    // random patterns
    for (int i = 0; i < 80; i++) begin
      pci_req  = 8'($urandom);
      misc_req = 8'($urandom) & 8'($urandom);
      if (($urandom % 2) == 0) wr(3'd0, 8'($urandom) | 8'($urandom));
      if (($urandom % 2) == 0) wr(3'd3, 8'($urandom) | 8'($urandom));
      if (($urandom % 3) == 0) wr(3'd2, 8'($urandom) | 8'($urandom));
      settle();
      check_all("rnd");
      rd(3'd0, v); chk("rnd R1 pci mask", v, m_pm);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule